// File: doc/BRIEF.md
# Dual-Input Dual-Output Packet Switch with Flagged-Packet Counter

This block moves packets from two input queues to two output queues and keeps a count of the packets that carry a "flagged" marker. Each input queue shows its head packet to the switch through a valid/ready pair, and the switch pops it by raising ready. Each output queue shows free space through its ready line, and the switch pushes a packet by raising valid. A packet's destination bit selects its output.

Every transfer is all-or-nothing. An input moves its head packet only when all four of these hold: the packet is present, its output has space, the input wins its output, and it wins the counter if the packet is flagged. In that case the pop, the push and the count step all take effect at the same clock edge. An input that loses does nothing, and the switch holds no packet between cycles. Two inputs that need different outputs, and do not both need the counter, move in the same cycle.

A mode pin sets how conflicts are resolved. One mode always favours input 0. The other alternates the favoured input after each conflict. The count can be read at any time and cleared synchronously.

Top module: `pkt_switch2x2`

## Requirements
- R1: A packet word is {dest, flag, payload}, with dest in the top bit and flag one bit below it. A packet with dest 0 appears unchanged on output 0, and a packet with dest 1 appears unchanged on output 1.
- R2: An input's ready is high only in a cycle where that input's valid is high and its chosen output's ready is high. In that cycle, the chosen output's valid is high and carries that input's packet.
- R3: Each output accepts at most one packet per cycle. When both inputs target the same output, exactly one of them transfers.
- R4: When both inputs could transfer and both packets are flagged, exactly one of them transfers, even if the destinations differ.
- R5: When both inputs can transfer to different outputs and at most one packet is flagged, both transfer in the same cycle.
- R6: With arb_mode = 0, input 0 wins every conflict.
- R7: With arb_mode = 1, the favoured input is input 0 after reset. The favoured input changes after every conflict, so repeated conflicts alternate the winner.
- R8: pkt_count rises by exactly 1 for each flagged packet that transfers. The new value is visible in the cycle after the transfer.
- R9: pkt_count holds at 2^CNT_W-1 instead of wrapping.
- R10: When cnt_clear is high at a clock edge, pkt_count becomes 0 after that edge. This holds even if a flagged packet transfers at the same edge.
- R11: Reset sets pkt_count to 0 and sets the fair pointer to favour input 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_mode | input | 1 | 0: input 0 always favoured; 1: alternating |
| cnt_clear | input | 1 | Synchronous clear of pkt_count |
| in0_valid | input | 1 | Input queue 0 has a head packet |
| in0_data | input | PAYLOAD_W+2 | Head packet of input queue 0 |
| in0_ready | output | 1 | Pop input queue 0 this cycle |
| in1_valid | input | 1 | Input queue 1 has a head packet |
| in1_data | input | PAYLOAD_W+2 | Head packet of input queue 1 |
| in1_ready | output | 1 | Pop input queue 1 this cycle |
| out0_valid | output | 1 | Push into output queue 0 this cycle |
| out0_data | output | PAYLOAD_W+2 | Packet pushed into output queue 0 |
| out0_ready | input | 1 | Output queue 0 has space |
| out1_valid | output | 1 | Push into output queue 1 this cycle |
| out1_data | output | PAYLOAD_W+2 | Packet pushed into output queue 1 |
| out1_ready | input | 1 | Output queue 1 has space |
| pkt_count | output | CNT_W | Saturating count of transferred flagged packets |

## Verification
If the fair pointer is wrong, the ports show it at the next conflict, because the wrong input's ready goes high in that same cycle. If the counter is wrong, pkt_count is off by the cycle after the faulty edge, and it stays off until the next clear. A misroute or a partial transfer shows up in the cycle it happens, as a ready with no matching valid or as a data mismatch. The bench model tracks queue contents, the pointer and the count, so the first wrong cycle is the one that gets reported.

// File: rtl/pktsw_pkg.sv
`timescale 1ns/1ps
package pktsw_pkg;

  typedef enum logic {
    ARB_FIXED = 1'b0,
    ARB_FAIR  = 1'b1
  } arb_mode_e;

  // Index of the input that wins a conflict this cycle.
  function automatic logic favoured_input(input arb_mode_e mode, input logic rr_ptr);
    return (mode == ARB_FAIR) ? rr_ptr : 1'b0;
  endfunction

endpackage

// File: rtl/sw_arbiter.sv
`timescale 1ns/1ps
module sw_arbiter
  import pktsw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  arb_mode_e mode,
  input  logic [1:0] req,
  input  logic [1:0] dest,
  input  logic [1:0] flag,
  output logic [1:0] grant,
  output logic       conflict
);

  logic rr_ptr;
  logic fav;

  // Both inputs ready to move, but they share an output or both need the counter.
  assign conflict = (&req) && ((dest[0] == dest[1]) || (&flag));
  assign fav      = favoured_input(mode, rr_ptr);

  for (genvar i = 0; i < 2; i++) begin : g_grant
    assign grant[i] = req[i] & (~conflict | (fav == 1'(i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               rr_ptr <= 1'b0;
    else if (mode == ARB_FAIR && conflict)    rr_ptr <= ~rr_ptr;
  end

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == 2'b00); // R2
  AST_ONE_PER_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (&req && dest[0] == dest[1]) |-> $countones(grant) == 1); // R3
  AST_ONE_COUNTER_USER: assert property (@(posedge clk) disable iff (!rst_n)
    (&req && &flag) |-> $countones(grant) == 1); // R4
  AST_DISJOINT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (&req && dest[0] != dest[1] && !(&flag)) |-> grant == 2'b11); // R5
  AST_FIXED_ZERO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ARB_FIXED && &req && (dest[0] == dest[1] || &flag)) |-> grant == 2'b01); // R6
  AST_FAIR_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ARB_FAIR && conflict) |=> rr_ptr != $past(rr_ptr)); // R7

endmodule

// File: rtl/sw_stat_counter.sv
`timescale 1ns/1ps
module sw_stat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= sat_step(count);
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0); // R10
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !clr) |=> count == CNT_MAX); // R9
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && count != CNT_MAX) |=> count == $past(count) + 1'b1); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(count)); // R8

endmodule

// File: rtl/pkt_switch2x2.sv
`timescale 1ns/1ps
module pkt_switch2x2
  import pktsw_pkg::*;
#(
  parameter int PAYLOAD_W = 8,
  parameter int CNT_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arb_mode,
  input  logic                 cnt_clear,
  input  logic                 in0_valid,
  input  logic [PAYLOAD_W+1:0] in0_data,
  output logic                 in0_ready,
  input  logic                 in1_valid,
  input  logic [PAYLOAD_W+1:0] in1_data,
  output logic                 in1_ready,
  output logic                 out0_valid,
  output logic [PAYLOAD_W+1:0] out0_data,
  input  logic                 out0_ready,
  output logic                 out1_valid,
  output logic [PAYLOAD_W+1:0] out1_data,
  input  logic                 out1_ready,
  output logic [CNT_W-1:0]     pkt_count
);

  localparam int DATA_W   = PAYLOAD_W + 2;
  localparam int DEST_BIT = DATA_W - 1;
  localparam int FLAG_BIT = DATA_W - 2;

  logic [DATA_W-1:0] head     [2];
  logic [DATA_W-1:0] out_dat  [2];
  logic [1:0]        in_vld, out_rdy, out_vld;
  logic [1:0]        pkt_dest, pkt_flag, req, grant;
  logic              conflict;
  logic              cnt_inc;

  assign head[0] = in0_data;
  assign head[1] = in1_data;
  assign in_vld  = {in1_valid, in0_valid};
  assign out_rdy = {out1_ready, out0_ready};

  for (genvar i = 0; i < 2; i++) begin : g_input
    assign pkt_dest[i] = head[i][DEST_BIT];
    assign pkt_flag[i] = head[i][FLAG_BIT];
    assign req[i]      = in_vld[i] & out_rdy[pkt_dest[i]];
  end

  sw_arbiter u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (arb_mode_e'(arb_mode)),
    .req      (req),
    .dest     (pkt_dest),
    .flag     (pkt_flag),
    .grant    (grant),
    .conflict (conflict)
  );

  for (genvar o = 0; o < 2; o++) begin : g_output
    logic [1:0] hit;
    assign hit[0]     = grant[0] & (pkt_dest[0] == 1'(o));
    assign hit[1]     = grant[1] & (pkt_dest[1] == 1'(o));
    assign out_vld[o] = |hit;
    assign out_dat[o] = hit[1] ? head[1] : (hit[0] ? head[0] : '0);
  end

  assign in0_ready  = grant[0];
  assign in1_ready  = grant[1];
  assign out0_valid = out_vld[0];
  assign out1_valid = out_vld[1];
  assign out0_data  = out_dat[0];
  assign out1_data  = out_dat[1];
  assign cnt_inc    = |(grant & pkt_flag);

  sw_stat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clear),
    .inc   (cnt_inc),
    .count (pkt_count)
  );

  AST_OUT_HAS_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld & ~out_rdy) == 2'b00); // R2
  AST_POP0_IS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    in0_ready |-> (in0_data[DEST_BIT] ? (out1_valid && out1_data == in0_data)
                                      : (out0_valid && out0_data == in0_data))); // R1
  AST_POP1_IS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    in1_ready |-> (in1_data[DEST_BIT] ? (out1_valid && out1_data == in1_data)
                                      : (out0_valid && out0_data == in1_data))); // R1
  AST_PUSH_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({out0_valid, out1_valid}) == $countones({in0_ready, in1_ready})); // R3

endmodule

// File: tb/pkt_switch2x2_tb.sv
`timescale 1ns/1ps
module pkt_switch2x2_tb;

  localparam int PW     = 8;
  localparam int DW     = PW + 2;
  localparam int CW     = 16;
  localparam int CMAX   = (1 << CW) - 1;
  localparam int OQ_CAP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arb_mode = 1'b0, cnt_clear = 1'b0;
  logic in0_valid = 1'b0, in1_valid = 1'b0, out0_ready = 1'b1, out1_ready = 1'b1;
  logic [DW-1:0] in0_data = '0, in1_data = '0;
  logic in0_ready, in1_ready, out0_valid, out1_valid;
  logic [DW-1:0] out0_data, out1_data;
  logic [CW-1:0] pkt_count;

  always #4 clk = ~clk;

  pkt_switch2x2 #(.PAYLOAD_W(PW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .arb_mode(arb_mode), .cnt_clear(cnt_clear),
    .in0_valid(in0_valid), .in0_data(in0_data), .in0_ready(in0_ready),
    .in1_valid(in1_valid), .in1_data(in1_data), .in1_ready(in1_ready),
    .out0_valid(out0_valid), .out0_data(out0_data), .out0_ready(out0_ready),
    .out1_valid(out1_valid), .out1_data(out1_data), .out1_ready(out1_ready),
    .pkt_count(pkt_count)
  );

  int vectors = 0, fails = 0;
  logic [DW-1:0] q0[$], q1[$];
  int  occ[2] = '{0, 0};
  bit  m_ptr = 1'b0;
  int  m_cnt = 0;
  bit  s_mode = 1'b0, s_clr = 1'b0;
  logic [1:0] last_grant;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] mk(input bit d, input bit f, input int p);
    return {d, f, 8'(p)};
  endfunction

  // One clock of stimulus plus a comparison against the behavioural model.
  task automatic step(input int drain_pct);
    bit v[2], d[2], f[2], sp[2], g[2], used_o[2], used_c, blocked;
    logic [DW-1:0] h[2];
    int fav;
    @(negedge clk);
    arb_mode  = s_mode;
    cnt_clear = s_clr;
    v[0] = q0.size() != 0;  h[0] = v[0] ? q0[0] : '0;
    v[1] = q1.size() != 0;  h[1] = v[1] ? q1[0] : '0;
    in0_valid = v[0]; in0_data = h[0];
    in1_valid = v[1]; in1_data = h[1];
    sp[0] = occ[0] < OQ_CAP; sp[1] = occ[1] < OQ_CAP;
    out0_ready = sp[0]; out1_ready = sp[1];
    // model: serve the favoured input first, then the other if its resources are left
    fav = s_mode ? int'(m_ptr) : 0;
    used_o = '{0, 0}; used_c = 0; blocked = 0; g = '{0, 0};
    for (int k = 0; k < 2; k++) begin
      int idx = (k == 0) ? fav : 1 - fav;
      d[idx] = h[idx][DW-1]; f[idx] = h[idx][DW-2];
      if (v[idx] && sp[d[idx]]) begin
        if (!used_o[d[idx]] && !(f[idx] && used_c)) begin
          g[idx] = 1; used_o[d[idx]] = 1;
          if (f[idx]) used_c = 1;
        end else blocked = 1;
      end
    end
    #1;
    chk(in0_ready == g[0], "R2 in0_ready", in0_ready, g[0]);
    chk(in1_ready == g[1], "R2 in1_ready", in1_ready, g[1]);
    for (int o = 0; o < 2; o++) begin
      bit ev = (g[0] && d[0] == o) || (g[1] && d[1] == o);
      logic [DW-1:0] ed = (g[1] && d[1] == o) ? h[1] : h[0];
      bit av = (o == 0) ? out0_valid : out1_valid;
      logic [DW-1:0] ad = (o == 0) ? out0_data : out1_data;
      chk(av == ev, "R3 out_valid", av, ev);
      if (ev) chk(ad == ed, "R1 out_data", ad, ed);
    end
    chk(int'(pkt_count) == m_cnt, "R8 pkt_count", pkt_count, m_cnt);
    last_grant = {in1_ready, in0_ready};
    // advance model state to the next cycle
    if (g[0]) begin void'(q0.pop_front()); occ[d[0]]++; end
    if (g[1]) begin void'(q1.pop_front()); occ[d[1]]++; end
    for (int o = 0; o < 2; o++)
      if (occ[o] > 0 && $urandom_range(0, 99) < drain_pct) occ[o]--;
    if (s_clr) m_cnt = 0;
    else if (((g[0] && f[0]) || (g[1] && f[1])) && m_cnt < CMAX) m_cnt++;
    if (s_mode && blocked) m_ptr = ~m_ptr;
  endtask

  task automatic flush();
    while (q0.size() != 0 || q1.size() != 0) step(100);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pkt_count == '0, "R11 count in reset", pkt_count, 0);
    rst_n = 1'b1;
    step(100);
    chk(last_grant == 2'b00, "R11 idle after reset", last_grant, 0);

    // R5: disjoint outputs, unflagged
    q0.push_back(mk(0, 0, 8'h11)); q1.push_back(mk(1, 0, 8'h22));
    step(100);
    chk(last_grant == 2'b11, "R5 both move", last_grant, 3);

    // R6: fixed priority on a shared output, twice in a row
    q0.push_back(mk(0, 0, 8'h31)); q1.push_back(mk(0, 0, 8'h32));
    step(100);
    chk(last_grant == 2'b01, "R6 input0 wins", last_grant, 1);
    q0.push_back(mk(0, 0, 8'h33));
    step(100);
    chk(last_grant == 2'b01, "R6 input0 wins again", last_grant, 1);
    step(100);
    chk(last_grant == 2'b10, "R6 loser then moves", last_grant, 2);

    // R4: counter contention with disjoint outputs
    q0.push_back(mk(0, 1, 8'h41)); q1.push_back(mk(1, 1, 8'h42));
    step(100);
    chk(last_grant == 2'b01, "R4 one counter user", last_grant, 1);
    step(100);
    step(100);
    chk(pkt_count == 16'd2, "R8 two flagged counted", pkt_count, 2);

    // R7: alternating winner in fair mode
    s_mode = 1'b1;
    for (int r = 0; r < 4; r++) begin
      q0.push_back(mk(1, 0, r)); q1.push_back(mk(1, 0, r + 16));
      step(100);
      chk(last_grant == ((r % 2 == 0) ? 2'b01 : 2'b10), "R7 alternation",
          last_grant, (r % 2 == 0) ? 1 : 2);
      flush();
    end

    // R10: clear beats a simultaneous flagged transfer
    q0.push_back(mk(0, 1, 8'h55));
    s_clr = 1'b1; step(100);
    s_clr = 1'b0; step(100);
    chk(pkt_count == '0, "R10 clear wins", pkt_count, 0);

    // mixed traffic with back-pressure
    for (int n = 0; n < 4000; n++) begin
      if (q0.size() < 4 && $urandom_range(0, 99) < 45)
        q0.push_back(mk($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 255)));
      if (q1.size() < 4 && $urandom_range(0, 99) < 45)
        q1.push_back(mk($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 255)));
      if ($urandom_range(0, 99) < 2) s_mode = ~s_mode;
      s_clr = ($urandom_range(0, 199) == 0);
      step(60);
    end
    s_clr = 1'b0;
    flush();

    // R9: drive to saturation
    s_mode = 1'b0; s_clr = 1'b1; step(100); s_clr = 1'b0;
    for (int n = 0; n < CMAX + 4; n++) begin
      q0.push_back(mk(n[0], 1, n));
      step(100);
    end
    step(100);
    chk(int'(pkt_count) == CMAX, "R9 saturated", pkt_count, CMAX);
    q1.push_back(mk(1, 1, 8'h99));
    step(100); step(100);
    chk(int'(pkt_count) == CMAX, "R9 holds at max", pkt_count, CMAX);

    finish_run();
  end

endmodule